// File: doc/BRIEF.md
# Raster timing generator with double-buffered timing registers

This block drives the raster timing of a display pipeline. A horizontal counter walks across each line and a vertical counter walks down the frame. Compares against programmable positions turn the two counts into sync pulses, a data-enable window, a blanking signal and a background-fill colour. The same counts produce two line-start strobes for the fetch and event logic downstream, and a vertical-blank interrupt.

Software programs the block through a plain word-addressed register port. A write completes in the cycle `reg_we` is high, and reads return data combinationally. There is no stream interface, so there is no back-pressure. The six timing words are written into a shadow copy. They reach the counters in one of two ways: one cycle later when bypass is on, or at the next start of vertical blanking once software has marked the shadow copy valid. The valid bit clears itself when the copy happens, so software can poll it. Power-down, sync enable, blanking polarity, interrupt enable and background colour act at once and are not shadowed.

Top module: `raster_timing_gen`

## Requirements
- R1: The horizontal count h runs 0..Htotal-1 and then wraps. The vertical count v advances when h wraps and runs 0..Vtotal-1. hsync is high while h < Hsync_end and vsync is high while v < Vsync_end, both only when the sync-enable bit is 1.
- R2: de is high when Hlead <= h < Hfront and Vlead <= v < Vfront.
- R3: A pixel is visible when Hact <= h < Hfront and Vact <= v < Vfront. blank equals "not visible" when the polarity bit is 1, and equals "visible" when the polarity bit is 0.
- R4: bg_pixel carries the background colour on a visible pixel that lies outside the plane (Hlead <= h < Htrail and Vlead <= v < Vtrail). On every other pixel it is 0.
- R5: vfetch_stb pulses for one cycle at h = 0 of line v = Vsync_end. vevent_stb pulses for one cycle at h = 0 of line v = Vtrail.
- R6: Vertical blanking starts at h = 0, v = Vfront. The status bit reads 1 from the following cycle. Writing 1 to bit 0 of word 9 clears it. irq = status AND enable (bit 0 of word 8).
- R7: Register map (word addresses). Words 0-2 are horizontal and words 3-5 are vertical; each word holds [15:0] / [31:16]. Word 0 holds sync_end / total, word 1 holds act / lead, word 2 holds front / trail. Word 6 holds bit0 power-down, bit1 sync enable and bit2 blank polarity. Word 7 holds bit0 bypass, bit1 use-vblank and bit2 valid. Word 10 holds the colour in [23:0]. Timing words read back their shadow value.
- R8: With bypass = 1, a timing write reaches the counters one cycle after it is written.
- R9: With bypass = 0, the active timing changes only at a blanking start where use-vblank = 1 and valid = 1. At that point valid reads 0 from the next cycle on. Without valid, shadow writes have no effect on the outputs.
- R10: While power-down is 1, both counters are held at 0. hsync, vsync, de, the strobes and bg_pixel stay 0, and blanking stays asserted.
- R11: After reset, power-down = 1, sync enable = 0, polarity = 1, the update word = 0, status = 0, and all timing words = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| blank | output | 1 | Blanking, polarity programmable |
| de | output | 1 | Data enable |
| bg_pixel | output | 24 | Background fill colour or 0 |
| vfetch_stb | output | 1 | Fetch-start line strobe |
| vevent_stb | output | 1 | Vertical event line strobe |
| irq | output | 1 | Vertical-blank interrupt |

## Verification
On every cycle, the assertions check the following: outputs stay idle and the counters stay cleared during power-down; the fetch strobe falls only on a line start; a blanking start always sets the status bit; an armed commit always clears the valid bit; and a frame wrap returns both counters to zero. The window positions of de, blank and the fill colour can only be shown by the bench's cycle-by-cycle sweeps against arithmetic expectations. The same holds for the difference between shadow writes made with and without valid, and for the exact cycle a commit lands.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
  localparam int POS_W   = 16;
  localparam int REG_W   = 2 * POS_W;
  localparam int COL_W   = 24;
  localparam int N_AXIS  = 2;
  localparam int N_TWORD = 3 * N_AXIS;

  localparam int A_SYNC  = N_TWORD;
  localparam int A_UPD   = N_TWORD + 1;
  localparam int A_IEN   = N_TWORD + 2;
  localparam int A_ISTAT = N_TWORD + 3;
  localparam int A_BG    = N_TWORD + 4;

  typedef struct packed {
    logic [POS_W-1:0] total;
    logic [POS_W-1:0] sync_end;
    logic [POS_W-1:0] brd_lead;
    logic [POS_W-1:0] act_start;
    logic [POS_W-1:0] brd_trail;
    logic [POS_W-1:0] front_start;
  } axis_cfg_t;

  function automatic axis_cfg_t unpack_axis(input logic [REG_W-1:0] w0,
                                            input logic [REG_W-1:0] w1,
                                            input logic [REG_W-1:0] w2);
    axis_cfg_t c;
    c.sync_end    = w0[POS_W-1:0];
    c.total       = w0[REG_W-1:POS_W];
    c.act_start   = w1[POS_W-1:0];
    c.brd_lead    = w1[REG_W-1:POS_W];
    c.front_start = w2[POS_W-1:0];
    c.brd_trail   = w2[REG_W-1:POS_W];
    return c;
  endfunction
endpackage

// File: rtl/rtg_axis.sv
module rtg_axis
  import rtg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             step,
  input  axis_cfg_t        cfg,
  output logic [POS_W-1:0] pos,
  output logic             carry,
  output logic             sync_raw,
  output logic             de_raw,
  output logic             vis_raw,
  output logic             plane_raw
);
  logic last;

  assign last      = (pos >= cfg.total - POS_W'(1));
  assign carry     = run && step && last;
  assign sync_raw  = (pos < cfg.sync_end);
  assign de_raw    = (pos >= cfg.brd_lead) && (pos < cfg.front_start);
  assign vis_raw   = (pos >= cfg.act_start) && (pos < cfg.front_start);
  assign plane_raw = (pos >= cfg.brd_lead) && (pos < cfg.brd_trail);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pos <= '0;
    else if (!run)  pos <= '0;
    else if (step)  pos <= last ? '0 : pos + POS_W'(1);
  end
endmodule

// File: rtl/rtg_regs.sv
module rtg_regs
  import rtg_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         we,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [REG_W-1:0]             wdata,
  input  logic                         vb_start,
  output axis_cfg_t [N_AXIS-1:0]       act_cfg,
  output logic                         pwr_down,
  output logic                         sync_en,
  output logic                         blank_pol,
  output logic                         int_en,
  output logic                         irq_stat,
  output logic [2:0]                   upd_ctl,
  output logic [COL_W-1:0]             bg_col,
  output logic [REG_W-1:0]             rdata
);
  logic [N_TWORD-1:0][REG_W-1:0] shadow;
  logic [N_TWORD-1:0][REG_W-1:0] active;
  logic commit, hit_sync, hit_upd, hit_ien, hit_istat, hit_bg;

  assign commit    = !upd_ctl[0] && upd_ctl[1] && upd_ctl[2] && vb_start;
  assign hit_sync  = we && (addr == ADDR_W'(A_SYNC));
  assign hit_upd   = we && (addr == ADDR_W'(A_UPD));
  assign hit_ien   = we && (addr == ADDR_W'(A_IEN));
  assign hit_istat = we && (addr == ADDR_W'(A_ISTAT));
  assign hit_bg    = we && (addr == ADDR_W'(A_BG));

  for (genvar w = 0; w < N_TWORD; w++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        shadow[w] <= '0;
        active[w] <= '0;
      end else begin
        if (we && (addr == ADDR_W'(w))) shadow[w] <= wdata;
        if (upd_ctl[0] || commit)       active[w] <= shadow[w];
      end
    end
  end

  for (genvar a = 0; a < N_AXIS; a++) begin : g_cfg
    assign act_cfg[a] = unpack_axis(active[3*a], active[3*a+1], active[3*a+2]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr_down  <= 1'b1;
      sync_en   <= 1'b0;
      blank_pol <= 1'b1;
      upd_ctl   <= '0;
      int_en    <= 1'b0;
      irq_stat  <= 1'b0;
      bg_col    <= '0;
    end else begin
      if (hit_sync) {blank_pol, sync_en, pwr_down} <= wdata[2:0];
      if (hit_upd)     upd_ctl    <= wdata[2:0];
      else if (commit) upd_ctl[2] <= 1'b0;
      if (hit_ien) int_en <= wdata[0];
      if (hit_bg)  bg_col <= wdata[COL_W-1:0];
      irq_stat <= (irq_stat && !(hit_istat && wdata[0])) || vb_start;
    end
  end

  always_comb begin
    rdata = '0;
    for (int w = 0; w < N_TWORD; w++)
      if (addr == ADDR_W'(w)) rdata = shadow[w];
    if (addr == ADDR_W'(A_SYNC))  rdata = REG_W'({blank_pol, sync_en, pwr_down});
    if (addr == ADDR_W'(A_UPD))   rdata = REG_W'(upd_ctl);
    if (addr == ADDR_W'(A_IEN))   rdata = REG_W'(int_en);
    if (addr == ADDR_W'(A_ISTAT)) rdata = REG_W'(irq_stat);
    if (addr == ADDR_W'(A_BG))    rdata = REG_W'(bg_col);
  end
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import rtg_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              hsync,
  output logic              vsync,
  output logic              blank,
  output logic              de,
  output logic [COL_W-1:0]  bg_pixel,
  output logic              vfetch_stb,
  output logic              vevent_stb,
  output logic              irq
);
  axis_cfg_t [N_AXIS-1:0] act_cfg;
  logic pwr_down, sync_en, blank_pol, int_en, irq_stat;
  logic [2:0]       upd_ctl;
  logic [COL_W-1:0] bg_col;
  logic [N_AXIS:0]  carry;
  logic [N_AXIS-1:0][POS_W-1:0] pos_a;
  logic [N_AXIS-1:0] sync_a, de_a, vis_a, plane_a;
  logic [POS_W-1:0] hpos, vpos;
  logic run, line_start, vb_start, visible, in_plane, frame_end;

  assign run      = !pwr_down;
  assign carry[0] = 1'b1;

  for (genvar a = 0; a < N_AXIS; a++) begin : g_axis
    rtg_axis u_axis (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run),
      .step     (carry[a]),
      .cfg      (act_cfg[a]),
      .pos      (pos_a[a]),
      .carry    (carry[a+1]),
      .sync_raw (sync_a[a]),
      .de_raw   (de_a[a]),
      .vis_raw  (vis_a[a]),
      .plane_raw(plane_a[a])
    );
  end

  assign hpos       = pos_a[0];
  assign vpos       = pos_a[N_AXIS-1];
  assign frame_end  = carry[N_AXIS];
  assign line_start = run && (hpos == '0);
  assign vb_start   = line_start && (vpos == act_cfg[N_AXIS-1].front_start);

  rtg_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (reg_we),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .vb_start (vb_start),
    .act_cfg  (act_cfg),
    .pwr_down (pwr_down),
    .sync_en  (sync_en),
    .blank_pol(blank_pol),
    .int_en   (int_en),
    .irq_stat (irq_stat),
    .upd_ctl  (upd_ctl),
    .bg_col   (bg_col),
    .rdata    (reg_rdata)
  );

  assign visible    = run && (&vis_a);
  assign in_plane   = &plane_a;
  assign hsync      = run && sync_en && sync_a[0];
  assign vsync      = run && sync_en && sync_a[N_AXIS-1];
  assign de         = run && (&de_a);
  assign blank      = blank_pol ? !visible : visible;
  assign bg_pixel   = (visible && !in_plane) ? bg_col : '0;
  assign vfetch_stb = line_start && (vpos == act_cfg[N_AXIS-1].sync_end);
  assign vevent_stb = line_start && (vpos == act_cfg[N_AXIS-1].brd_trail);
  assign irq        = irq_stat && int_en;
endmodule

// File: rtl/rtg_checker.sv
module rtg_checker
  import rtg_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pwr_down,
  input logic [POS_W-1:0]  hpos,
  input logic [POS_W-1:0]  vpos,
  input logic              hsync,
  input logic              vsync,
  input logic              de,
  input logic              vfetch_stb,
  input logic              vb_start,
  input logic              irq_stat,
  input logic [2:0]        upd_ctl,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              frame_end
);
  AST_PD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |-> (!hsync && !vsync && !de)); // R10
  AST_PD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |=> (hpos == '0 && vpos == '0)); // R10
  AST_FETCH_LINE_START: assert property (@(posedge clk) disable iff (!rst_n)
    vfetch_stb |-> (hpos == '0)); // R5
  AST_STAT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    vb_start |=> irq_stat); // R6
  AST_VALID_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (vb_start && upd_ctl == 3'b110 && !(reg_we && reg_addr == ADDR_W'(A_UPD)))
      |=> !upd_ctl[2]); // R9
  AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> (hpos == '0 && vpos == '0)); // R1
endmodule

bind raster_timing_gen rtg_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pwr_down  (pwr_down),
  .hpos      (hpos),
  .vpos      (vpos),
  .hsync     (hsync),
  .vsync     (vsync),
  .de        (de),
  .vfetch_stb(vfetch_stb),
  .vb_start  (vb_start),
  .irq_stat  (irq_stat),
  .upd_ctl   (upd_ctl),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .frame_end (frame_end)
);

// File: tb/raster_timing_gen_test.sv
module raster_timing_gen_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic hsync, vsync, blank, de, vfetch_stb, vevent_stb, irq;
  logic [23:0] bg_pixel;

  always #4 clk = ~clk;

  raster_timing_gen #(.ADDR_W(4)) uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hsync(hsync), .vsync(vsync),
    .blank(blank), .de(de), .bg_pixel(bg_pixel), .vfetch_stb(vfetch_stb),
    .vevent_stb(vevent_stb), .irq(irq)
  );

  int n_chk = 0, n_fail = 0;
  string phase = "reset";
  // bench model of the register state and counters
  logic [31:0] S [6];
  logic [31:0] A [6];
  logic [2:0]  m_sync = 3'b101;
  logic [2:0]  m_upd = 3'b000;
  logic        m_en = 1'b0, m_stat = 1'b0;
  logic [23:0] m_bg = '0;
  int hm = 0, vm = 0;
  logic pw = 1'b0;
  int pa = 0;
  logic [31:0] pdat = '0;

  function automatic int lo(input logic [31:0] w); return int'(w[15:0]); endfunction
  function automatic int hi(input logic [31:0] w); return int'(w[31:16]); endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s [%s] t=%0t: actual %0h expected %0h", tag, phase, $time, got, exp);
    end
  endtask

  task automatic compare();
    logic run, vis, pl, hde, vde;
    run = !m_sync[0];
    hde = hm >= hi(A[1]) && hm < lo(A[2]);
    vde = vm >= hi(A[4]) && vm < lo(A[5]);
    vis = run && hm >= lo(A[1]) && hm < lo(A[2]) && vm >= lo(A[4]) && vm < lo(A[5]);
    pl  = hm >= hi(A[1]) && hm < hi(A[2]) && vm >= hi(A[4]) && vm < hi(A[5]);
    chk("R1 hsync", 32'(hsync), 32'(run && m_sync[1] && hm < lo(A[0])));
    chk("R1 vsync", 32'(vsync), 32'(run && m_sync[1] && vm < lo(A[3])));
    chk("R2 de", 32'(de), 32'(run && hde && vde));
    chk("R3 blank", 32'(blank), 32'(m_sync[2] ? !vis : vis));
    chk("R4 bg_pixel", 32'(bg_pixel), (vis && !pl) ? 32'(m_bg) : 32'd0);
    chk("R5 vfetch", 32'(vfetch_stb), 32'(run && hm == 0 && vm == lo(A[3])));
    chk("R5 vevent", 32'(vevent_stb), 32'(run && hm == 0 && vm == hi(A[5])));
    chk("R6 irq", 32'(irq), 32'(m_stat && m_en));
  endtask

  task automatic step();
    logic vbs, commit;
    vbs = !m_sync[0] && hm == 0 && vm == lo(A[5]);
    commit = !m_upd[0] && m_upd[1] && m_upd[2] && vbs;
    if (m_sync[0]) begin hm = 0; vm = 0; end
    else if (hm >= hi(A[0]) - 1) begin
      hm = 0;
      if (vm >= hi(A[3]) - 1) vm = 0; else vm++;
    end else hm++;
    m_stat = (m_stat && !(pw && pa == 9 && pdat[0])) || vbs;
    if (m_upd[0] || commit) for (int i = 0; i < 6; i++) A[i] = S[i];
    if (commit) m_upd[2] = 1'b0;
    if (pw) begin
      if (pa < 6) S[pa] = pdat;
      if (pa == 6) m_sync = pdat[2:0];
      if (pa == 7) m_upd = pdat[2:0];
      if (pa == 8) m_en = pdat[0];
      if (pa == 10) m_bg = pdat[23:0];
    end
    pw = 1'b0;
  endtask

  task automatic tick();
    step();
    @(negedge clk);
    compare();
  endtask

  task automatic run_n(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = 4'(a); reg_wdata = d;
    pw = 1'b1; pa = a; pdat = d;
    tick();
    reg_we = 1'b0;
  endtask

  task automatic rd(input int a, input logic [31:0] exp, input string tag);
    reg_addr = 4'(a);
    #1;
    chk(tag, reg_rdata, exp);
  endtask

  initial begin
    for (int i = 0; i < 6; i++) begin S[i] = '0; A[i] = '0; end
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 hsync", 32'(hsync), 0);
    chk("R11 de", 32'(de), 0);
    chk("R11 blank", 32'(blank), 1);
    chk("R11 irq", 32'(irq), 0);
    rd(6, 32'h5, "R11 sync word");
    rd(7, 32'h0, "R11 update word");
    rd(9, 32'h0, "R11 status");
    rd(2, 32'h0, "R11 timing word");
    rst_n = 1'b1;
    @(negedge clk);
    compare();

    phase = "R8 bypass load";
    wr(7, 32'h1);
    wr(0, {16'd12, 16'd2});
    wr(1, {16'd4, 16'd3});
    wr(2, {16'd8, 16'd9});
    wr(3, {16'd8, 16'd1});
    wr(4, {16'd3, 16'd2});
    wr(5, {16'd5, 16'd6});
    wr(10, 32'h00A5C3);
    rd(2, {16'd8, 16'd9}, "R7 shadow readback");
    rd(10, 32'h00A5C3, "R7 colour readback");
    phase = "R1 sweep pol1";
    wr(6, 32'h6);
    run_n(200);
    phase = "R3 sweep pol0";
    wr(6, 32'h2);
    run_n(100);
    phase = "R8 bypass change";
    wr(2, {16'd7, 16'd10});
    run_n(100);

    phase = "R6 interrupt";
    wr(8, 32'h1);
    for (int i = 0; i < 300 && !m_stat; i++) tick();
    rd(9, 32'h1, "R6 status set");
    tick();
    wr(9, 32'h1);
    rd(9, 32'(m_stat), "R6 status cleared");
    run_n(20);

    phase = "R9 no valid";
    wr(7, 32'h2);
    wr(0, {16'd14, 16'd3});
    wr(2, {16'd9, 16'd11});
    wr(5, {16'd4, 16'd5});
    run_n(250);
    rd(7, 32'h2, "R9 update word idle");
    phase = "R9 commit";
    wr(7, 32'h6);
    rd(7, 32'h6, "R9 valid pending");
    run_n(250);
    rd(7, 32'h2, "R9 valid self-clear");

    phase = "R10 powerdown";
    wr(6, 32'h3);
    run_n(40);
    phase = "R10 restart";
    wr(6, 32'h6);
    run_n(120);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule